// File: doc/BRIEF.md
# Ethernet destination address filter

This block sits at the front of a receive path and decides, from the destination address of an incoming frame, whether the frame is kept. The six address bytes arrive one per valid cycle on a byte stream, first byte first. A separate strobe marks that the address is complete. The block compares the address with the station address. It recognises the all-ones broadcast address. It also looks up a 64-entry multicast hash table, indexed by six bits of a running CRC-32 of the address bytes.

Static configuration comes in on plain inputs: two station address words, two 32-bit hash words and three mode bits. The mode bits are broadcast reject, promiscuous and hash lookup for unicast addresses. One cycle after the address-done strobe the block gives a registered accept decision with a one-cycle valid pulse. It also gives a flag that says the frame was accepted through the hash table. The decision holds until the next start-of-frame pulse, which returns the block to idle.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_by_hash` are all 0.
- R2: `dec_valid` is high for exactly the one cycle after a cycle with `addr_done` high and `sof` low. `dec_accept` and `dec_by_hash` keep their value until the next `sof`. The cycle after `sof`, all three outputs are 0. `sof` wins over `addr_done` in the same cycle.
- R3: Address byte 0 (the first byte received) is compared with `stn_hi[15:8]` and byte 1 with `stn_hi[7:0]`. Bytes 2, 3, 4 and 5 are compared with `stn_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. An exact match is accepted with `dec_by_hash`=0, whatever the group bit, the modes (other than promiscuous) and the hash words.
- R4: The address FF:FF:FF:FF:FF:FF, when it does not match the station address, is accepted when `mode_bcast_rej`=0 and rejected when it is 1, with `dec_by_hash`=0.
- R5: With `mode_promisc`=1 every frame is accepted with `dec_by_hash`=0.
- R6: A non-broadcast address with bit 0 of byte 0 set (group address) that does not match the station address is accepted only when its hash bit is 1. The hash index is bits 31:26 of a CRC. The CRC starts at 0xFFFFFFFF and uses polynomial 0x04C11DB7. It takes the six bytes in order, each byte LSB first, and has no final inversion. Index bit 5 selects `hash_hi` (1) or `hash_lo` (0); index bits 4:0 pick the bit.
- R7: With both hash words all ones, every group address is accepted.
- R8: A unicast address (bit 0 of byte 0 clear) that does not match the station address is rejected when `mode_ia_hash`=0. When `mode_ia_hash`=1 it is accepted exactly when its hash bit, per R6, is set.
- R9: Only the first six `byte_vld` bytes after `sof` count. Further bytes before the next `sof` are ignored, and so is a byte presented in the same cycle as `sof`.
- R10: `dec_by_hash` is 1 exactly when the frame was accepted through a hash lookup (R6 or R8), and it is never 1 while `dec_accept` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse, returns the filter to idle |
| byte_vld | input | 1 | `byte_data` holds an address byte |
| byte_data | input | 8 | Address byte, byte 0 first |
| addr_done | input | 1 | Address complete strobe |
| stn_lo | input | 32 | Station address bytes 2..5, byte 2 in the top bits |
| stn_hi | input | 16 | Station address bytes 0..1, byte 0 in the top bits |
| hash_lo | input | 32 | Hash table entries 0..31 |
| hash_hi | input | 32 | Hash table entries 32..63 |
| mode_bcast_rej | input | 1 | Reject broadcast frames |
| mode_promisc | input | 1 | Accept every frame |
| mode_ia_hash | input | 1 | Look up non-matching unicast addresses in the hash table |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_by_hash | output | 1 | Acceptance came from the hash table |

## Verification
The block has no top-level parameters. The bench builds it with the package defaults: six address bytes, 8-bit bytes, a 6-bit hash index and two 32-bit hash words. These values make both hash words and every branch of the decision reachable. The bench computes each address's hash index on its own and sets or clears only that bit. This shows that a single table entry decides group and unicast lookups. Frames with extra trailing bytes and a byte in the start-of-frame cycle test that the address capture stops at six and ignores the start-of-frame cycle.

// File: rtl/dafl_pkg.sv
// Shared constants and the byte-wise CRC step for the destination filter.
// Assumes bytes are fed LSB first into a left-shifting CRC register.
package dafl_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam int CRC_W      = 32;
    localparam int HASH_IDX_W = 6;
    localparam int HASH_REG_W = 32;
    localparam int HSEL_W     = HASH_IDX_W - 1;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    // One byte of CRC update, data bit 0 first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY;
            else                   r = r << 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/dafl_collect.sv
// Captures the first ADDR_BYTES bytes after a start-of-frame into an
// address word, byte 0 in the top bits. Assumes sof precedes each frame.
module dafl_collect
    import dafl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              take,
    output logic [ADDR_W-1:0] addr
);
    logic [CNT_W-1:0] cnt_q;

    assign take = byte_vld && !sof && (cnt_q < CNT_W'(ADDR_BYTES));

    // Count the captured bytes, restarting at each frame.
    always_ff @(posedge clk) begin
        if (!rst_n || sof) cnt_q <= '0;
        else if (take)     cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] b_q;
        // Hold address byte g once its slot comes up.
        always_ff @(posedge clk) begin
            if (!rst_n || sof)                     b_q <= '0;
            else if (take && cnt_q == CNT_W'(g))   b_q <= byte_data;
        end
        assign addr[ADDR_W-1-g*BYTE_W -: BYTE_W] = b_q;
    end
endmodule

// File: rtl/dafl_crc_acc.sv
// Running CRC-32 over the captured address bytes; exposes only the hash
// index (top bits, no final inversion). Assumes take marks counted bytes.
module dafl_crc_acc
    import dafl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sof,
    input  logic                  take,
    input  logic [BYTE_W-1:0]     byte_data,
    output logic [HASH_IDX_W-1:0] hash_idx
);
    logic [CRC_W-1:0] crc_q;

    // Seed at frame start, fold in each counted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || sof) crc_q <= CRC_SEED;
        else if (take)     crc_q <= crc_step(crc_q, byte_data);
    end

    assign hash_idx = crc_q[CRC_W-1 -: HASH_IDX_W];
endmodule

// File: rtl/dafl_judge.sv
// Combinational accept decision from the captured address, hash index,
// station address, hash table and mode bits. Priority: promiscuous,
// station match, broadcast, hash lookup.
module dafl_judge
    import dafl_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  logic [HASH_IDX_W-1:0] hash_idx,
    input  logic [ADDR_W-1:0]     station,
    input  logic [HASH_REG_W-1:0] hash_lo,
    input  logic [HASH_REG_W-1:0] hash_hi,
    input  logic                  mode_bcast_rej,
    input  logic                  mode_promisc,
    input  logic                  mode_ia_hash,
    output logic                  accept,
    output logic                  by_hash
);
    logic is_group, is_bcast, is_match, hbit;

    assign is_group = addr[ADDR_W-BYTE_W];
    assign is_bcast = &addr;
    assign is_match = (addr == station);
    assign hbit     = hash_idx[HSEL_W] ? hash_hi[hash_idx[HSEL_W-1:0]]
                                       : hash_lo[hash_idx[HSEL_W-1:0]];

    // Pick the rule that applies and its outcome.
    always_comb begin
        accept  = 1'b0;
        by_hash = 1'b0;
        if (mode_promisc || is_match) begin
            accept = 1'b1;
        end else if (is_bcast) begin
            accept = !mode_bcast_rej;
        end else if (is_group || mode_ia_hash) begin
            accept  = hbit;
            by_hash = hbit;
        end
    end
endmodule

// File: rtl/dst_addr_filter.sv
// Destination address filter top: capture, CRC hash index, decision and
// the registered result. Assumes addr_done comes after the last byte.
module dst_addr_filter
    import dafl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sof,
    input  logic                  byte_vld,
    input  logic [BYTE_W-1:0]     byte_data,
    input  logic                  addr_done,
    input  logic [31:0]           stn_lo,
    input  logic [15:0]           stn_hi,
    input  logic [HASH_REG_W-1:0] hash_lo,
    input  logic [HASH_REG_W-1:0] hash_hi,
    input  logic                  mode_bcast_rej,
    input  logic                  mode_promisc,
    input  logic                  mode_ia_hash,
    output logic                  dec_valid,
    output logic                  dec_accept,
    output logic                  dec_by_hash
);
    logic                  take;
    logic [ADDR_W-1:0]     addr;
    logic [HASH_IDX_W-1:0] hash_idx;
    logic                  j_accept, j_by_hash;

    dafl_collect u_collect (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .byte_data(byte_data), .take(take), .addr(addr)
    );

    dafl_crc_acc u_crc (
        .clk(clk), .rst_n(rst_n), .sof(sof), .take(take),
        .byte_data(byte_data), .hash_idx(hash_idx)
    );

    dafl_judge u_judge (
        .addr(addr), .hash_idx(hash_idx), .station({stn_hi, stn_lo}),
        .hash_lo(hash_lo), .hash_hi(hash_hi),
        .mode_bcast_rej(mode_bcast_rej), .mode_promisc(mode_promisc),
        .mode_ia_hash(mode_ia_hash), .accept(j_accept), .by_hash(j_by_hash)
    );

    // Register the decision on addr_done and hold it until the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n || sof) begin
            dec_valid   <= 1'b0;
            dec_accept  <= 1'b0;
            dec_by_hash <= 1'b0;
        end else begin
            dec_valid <= addr_done;
            if (addr_done) begin
                dec_accept  <= j_accept;
                dec_by_hash <= j_by_hash;
            end
        end
    end
endmodule

// File: rtl/dafl_checker.sv
// Port-level properties of the destination filter, bound to the top.
module dafl_checker (
    input logic clk,
    input logic rst_n,
    input logic sof,
    input logic addr_done,
    input logic mode_promisc,
    input logic dec_valid,
    input logic dec_accept,
    input logic dec_by_hash
);
    // R2: a decision strobe follows every unpreempted addr_done
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && !sof) |=> dec_valid);
    // R2: no strobe without addr_done in the cycle before
    assert_valid_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_done || sof) |=> !dec_valid);
    // R2: start of frame clears the result
    assert_sof_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (!dec_accept && !dec_by_hash));
    // R2: result held between decisions
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && !addr_done) |=> ($stable(dec_accept) && $stable(dec_by_hash)));
    // R5: promiscuous accepts without the hash
    assert_promisc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && !sof && mode_promisc) |=> (dec_accept && !dec_by_hash));
    // R10: hash flag implies acceptance
    assert_hash_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_by_hash |-> dec_accept);
endmodule

bind dst_addr_filter dafl_checker u_dafl_checker (
    .clk(clk), .rst_n(rst_n), .sof(sof), .addr_done(addr_done),
    .mode_promisc(mode_promisc), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_by_hash(dec_by_hash)
);

// File: tb/dst_addr_filter_bench.sv
module dst_addr_filter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0, byte_vld = 1'b0, addr_done = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [31:0] stn_lo = '0;
    logic [15:0] stn_hi = '0;
    logic [31:0] hash_lo = '0, hash_hi = '0;
    logic        mode_bcast_rej = 1'b0, mode_promisc = 1'b0, mode_ia_hash = 1'b0;
    logic        dec_valid, dec_accept, dec_by_hash;

    int total = 0, bad = 0, cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dst_addr_filter u_dst_addr_filter (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_vld(byte_vld),
        .byte_data(byte_data), .addr_done(addr_done), .stn_lo(stn_lo),
        .stn_hi(stn_hi), .hash_lo(hash_lo), .hash_hi(hash_hi),
        .mode_bcast_rej(mode_bcast_rej), .mode_promisc(mode_promisc),
        .mode_ia_hash(mode_ia_hash), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_by_hash(dec_by_hash)
    );

    // Independent hash index: bytes in order, bits LSB first, no inversion.
    function automatic int hidx(input logic [47:0] a);
        longint unsigned c = 64'hFFFFFFFF;
        for (int k = 0; k < 6; k++) begin
            int bt = int'(a[47-8*k -: 8]);
            for (int b = 0; b < 8; b++) begin
                int fb = int'((c >> 31) & 1) ^ ((bt >> b) & 1);
                c = (c << 1) & 64'hFFFFFFFF;
                if (fb != 0) c = c ^ 64'h04C11DB7;
            end
        end
        return int'(c >> 26);
    endfunction

    function automatic bit hbit_of(input logic [47:0] a);
        int i = hidx(a);
        return (i >= 32) ? hash_hi[i-32] : hash_lo[i];
    endfunction

    // Behavioural reference: byte queue and expected outputs.
    byte unsigned mq[$];
    bit e_valid = 0, e_acc = 0, e_hash = 0;

    always @(posedge clk) begin
        if (!rst_n || sof) begin
            mq.delete();
            e_valid <= 0; e_acc <= 0; e_hash <= 0;
        end else begin
            e_valid <= addr_done;
            if (addr_done) begin
                logic [47:0] a = '0;
                bit acc, hh;
                for (int k = 0; k < mq.size(); k++) a[47-8*k -: 8] = mq[k];
                acc = 0; hh = 0;
                if (mode_promisc || a == {stn_hi, stn_lo}) acc = 1;
                else if (a == 48'hFFFFFFFFFFFF) acc = !mode_bcast_rej;
                else if (a[40] || mode_ia_hash) begin acc = hbit_of(a); hh = acc; end
                e_acc <= acc; e_hash <= hh;
            end
            if (byte_vld && mq.size() < 6) mq.push_back(byte_data);
        end
    end

    // Per-cycle comparison against the reference (R2 timing and holding).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if ({dec_valid, dec_accept, dec_by_hash} != {e_valid, e_acc, e_hash}) begin
                bad++;
                $display("FAIL R2 per-cycle model: actual=%b%b%b expected=%b%b%b",
                         dec_valid, dec_accept, dec_by_hash, e_valid, e_acc, e_hash);
            end
        end
    end

    task automatic chk(input string tag, input bit v, input bit a, input bit h);
        total++;
        if ({dec_valid, dec_accept, dec_by_hash} != {v, a, h}) begin
            bad++;
            $display("FAIL %s: actual=%b%b%b expected=%b%b%b", tag,
                     dec_valid, dec_accept, dec_by_hash, v, a, h);
        end
    endtask

    // Send one address; returns at the negedge where dec_valid is expected high.
    task automatic send(input logic [47:0] a, input int extra, input bit junk_at_sof);
        @(negedge clk);
        sof = 1; byte_vld = junk_at_sof; byte_data = 8'hFF;
        @(negedge clk);
        sof = 0; byte_vld = 0;
        for (int k = 0; k < 6 + extra; k++) begin
            byte_vld = 1;
            byte_data = (k < 6) ? a[47-8*k -: 8] : 8'hC3;
            @(negedge clk);
        end
        byte_vld = 0; addr_done = 1;
        @(negedge clk);
        addr_done = 0;
    endtask

    task automatic set_only_bit(input logic [47:0] a);
        int i = hidx(a);
        hash_lo = '0; hash_hi = '0;
        if (i >= 32) hash_hi[i-32] = 1'b1; else hash_lo[i] = 1'b1;
    endtask

    initial begin
        logic [47:0] mc1 = 48'h01005E000001;
        logic [47:0] uc1 = 48'h02AABBCCDDEE;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset state", 0, 0, 0);

        stn_hi = 16'h0211; stn_lo = 32'h22334455;
        send(48'h021122334455, 0, 0);
        chk("R3 station match", 1, 1, 0);
        @(negedge clk);
        chk("R2 strobe one cycle, result held", 0, 1, 0);
        send(48'h021122335544, 0, 0);
        chk("R3 byte order swapped rejected / R8 ia off", 1, 0, 0);
        send(48'h445533221102, 0, 0);
        chk("R3 reversed order no match", 1, 0, 0);

        stn_hi = 16'h01AA; stn_lo = 32'h12345678;
        send(48'h01AA12345678, 0, 0);
        chk("R3 group-bit station match with empty hash", 1, 1, 0);

        send(48'hFFFFFFFFFFFF, 0, 0);
        chk("R4 broadcast accepted", 1, 1, 0);
        mode_bcast_rej = 1;
        send(48'hFFFFFFFFFFFF, 0, 0);
        chk("R4 broadcast rejected", 1, 0, 0);

        mode_promisc = 1;
        send(48'hFFFFFFFFFFFF, 0, 0);
        chk("R5 promiscuous broadcast", 1, 1, 0);
        send(uc1, 0, 0);
        chk("R5 promiscuous unicast", 1, 1, 0);
        mode_promisc = 0;

        set_only_bit(mc1);
        send(mc1, 0, 0);
        chk("R6 R10 multicast hash hit", 1, 1, 1);
        hash_lo = ~hash_lo; hash_hi = ~hash_hi;
        send(mc1, 0, 0);
        chk("R6 multicast hash miss", 1, 0, 0);
        set_only_bit(48'h3300000000AB);
        send(48'h3300000000AB, 0, 0);
        chk("R6 second multicast index", 1, 1, 1);

        hash_lo = '1; hash_hi = '1;
        send(48'h0180C2000001, 0, 0);
        chk("R7 all-ones hash", 1, 1, 1);
        send(48'hABCDEF012345, 0, 0);
        chk("R7 all-ones hash other group", 1, 1, 1);

        send(uc1, 0, 0);
        chk("R8 unicast miss ia off", 1, 0, 0);
        mode_ia_hash = 1;
        set_only_bit(uc1);
        send(uc1, 0, 0);
        chk("R8 R10 unicast via hash", 1, 1, 1);
        hash_lo = ~hash_lo; hash_hi = ~hash_hi;
        send(uc1, 0, 0);
        chk("R8 unicast hash miss", 1, 0, 0);
        mode_ia_hash = 0;

        send(48'h01AA12345678, 3, 1);
        chk("R9 extra bytes and sof byte ignored", 1, 1, 0);
        set_only_bit(mc1);
        send(mc1, 4, 1);
        chk("R9 extra bytes leave hash index", 1, 1, 1);

        @(negedge clk);
        sof = 1; addr_done = 1;
        @(negedge clk);
        sof = 0; addr_done = 0;
        chk("R2 sof clears and beats addr_done", 0, 0, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule